// File: doc/BRIEF.md
# Nibble-Table Constant Multiplier

This block multiplies an 8-bit unsigned sample by an unsigned 8-bit coefficient that is fixed when the design is elaborated. It contains no multiplier array. The sample is split into its two 4-bit halves. Each half selects one entry from its own 16-entry table of coefficient multiples. The entry chosen by the upper half is weighted by sixteen, the two entries are added, and the 16-bit sum is the exact product.

The tables are filled at elaboration by a package function of the coefficient parameter, so the block needs no memory image. A single register stage sits between the input and the output. A valid flag travels through that stage beside the product, so results come out one clock after the sample is presented. The block accepts a new sample on every cycle.

Top module: `nibble_rom_kmul`

## Requirements
- R1: A synchronous active-high reset drives `out_valid` and `out_product` to zero on the next clock edge. This holds even when `in_valid` is high in that cycle.
- R2: Outside reset, `out_valid` equals the value `in_valid` had one clock earlier.
- R3: For every sample x in 0..255 accepted with `in_valid` high, `out_product` one clock later equals x·K exactly, where K is the elaboration-time coefficient in 0..255.
- R4: The low nibble `in_data[3:0]` contributes j·K and the high nibble `in_data[7:4]` contributes 16·j·K. A sample of 8'h0F therefore yields 15·K and 8'hF0 yields 240·K. Each table entry fits in 12 bits.
- R5: While `in_valid` is low, `out_product` keeps its last value whatever `in_data` does.
- R6: Extreme coefficients are exact. K=0 always gives 0, K=1 gives x, and K=255 with x=255 gives 65025 without overflow.
- R7: Samples on consecutive cycles each produce their own product on consecutive cycles, with no bubble between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on `in_data` |
| in_data | input | 8 | Unsigned sample |
| out_valid | output | 1 | Product on `out_product` is fresh |
| out_product | output | 16 | Registered sample times K |

## Verification
Two things can happen in the same cycle.

- Capture and presentation overlap. A new sample is captured on the same edge that the previous product is being presented. Full sweeps drive every input value back to back on four coefficient instances (K = 0, 1, 173, 255). Each output is compared on the next cycle with a product the bench computes itself.
- Reset and a valid sample coincide. Reset is raised while a valid sample is being driven. The outputs must come back as zero rather than as the product.

Random runs from a fixed seed mix idle and valid cycles. In those runs the held product must not drift while `in_valid` is low.

// File: rtl/kcm_pkg.sv
package kcm_pkg;
    parameter int unsigned NIB_W  = 4;
    parameter int unsigned COEF_W = 8;
    localparam int unsigned DATA_W = 2 * NIB_W;
    localparam int unsigned NIB_N  = 1 << NIB_W;
    localparam int unsigned PP_W   = NIB_W + COEF_W;
    localparam int unsigned PROD_W = DATA_W + COEF_W;
    localparam int unsigned SEG_N  = DATA_W / NIB_W;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [PP_W-1:0]   pp_t;
    typedef logic [PROD_W-1:0] prod_t;

    typedef struct packed {
        logic  vld;
        prod_t prod;
    } result_t;

    // Entry idx of a table holds idx multiples of the coefficient.
    function automatic pp_t table_entry(int unsigned idx, int unsigned k);
        return pp_t'(idx * (k % (1 << COEF_W)));
    endfunction
endpackage

// File: rtl/kcm_lut.sv
module kcm_lut
    import kcm_pkg::*;
#(
    parameter int unsigned K = 0
) (
    input  nib_t addr,
    output pp_t  data
);
    pp_t rom [NIB_N];

    for (genvar g = 0; g < NIB_N; g++) begin : g_entry
        assign rom[g] = table_entry(g, K);
    end

    assign data = rom[addr];
endmodule

// File: rtl/kcm_align_add.sv
module kcm_align_add
    import kcm_pkg::*;
(
    input  pp_t   lo_pp,
    input  pp_t   hi_pp,
    output prod_t sum
);
    prod_t lo_ext;
    prod_t hi_shf;

    assign lo_ext = prod_t'(lo_pp);
    assign hi_shf = prod_t'({hi_pp, {NIB_W{1'b0}}});
    assign sum    = lo_ext + hi_shf;
endmodule

// File: rtl/nibble_rom_kmul.sv
module nibble_rom_kmul
    import kcm_pkg::*;
#(
    parameter int unsigned K = 173
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [PROD_W-1:0] out_product
);
    localparam int unsigned KC = K % (1 << COEF_W);

    pp_t     pp [SEG_N];
    prod_t   sum;
    result_t res_q;

    for (genvar n = 0; n < SEG_N; n++) begin : g_seg
        kcm_lut #(.K(KC)) u_lut (
            .addr (in_data[n*NIB_W +: NIB_W]),
            .data (pp[n])
        );
    end

    kcm_align_add u_add (
        .lo_pp (pp[0]),
        .hi_pp (pp[1]),
        .sum   (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= in_valid;
            if (in_valid) begin
                res_q.prod <= sum;
            end
        end
    end

    assign out_valid   = res_q.vld;
    assign out_product = res_q.prod;

    // R1: reset clears both outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_product == '0));

    // R2: valid flag delayed by exactly one clock
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    // R3: registered result equals the true product
    p_exact_product_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst)) |->
        out_product == prod_t'(prod_t'($past(in_data)) * prod_t'(KC)));

    // R4: low-nibble table output never exceeds 15 multiples
    p_table_bound_r4: assert property (@(posedge clk) disable iff (rst)
        pp[0] <= pp_t'((NIB_N - 1) * KC));

    // R5: product held while no sample is accepted
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> $stable(out_product));
endmodule

// File: tb/nibble_rom_kmul_test.sv
module nibble_rom_kmul_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        v_a, v_0, v_1, v_f;
    logic [15:0] p_a, p_0, p_1, p_f;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    localparam int unsigned KA = 173;

    always #10 clk = ~clk;

    nibble_rom_kmul #(.K(KA))  uut      (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(v_a), .out_product(p_a));
    nibble_rom_kmul #(.K(0))   uut_k0   (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(v_0), .out_product(p_0));
    nibble_rom_kmul #(.K(1))   uut_k1   (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(v_1), .out_product(p_1));
    nibble_rom_kmul #(.K(255)) uut_k255 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .out_valid(v_f), .out_product(p_f));

    function automatic logic [15:0] ref_mul(int unsigned k, int unsigned x);
        return 16'(k * x);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at the falling edge, sample 1 ns after the rising edge
    task automatic cyc(input logic v, input logic [7:0] d);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] ha, h0, h1, hf;
        logic        ev;
        void'($urandom(32'd4242));

        // R1: reset, with a valid sample presented during reset
        cyc(1'b1, 8'hFF);
        cyc(1'b1, 8'hFF);
        chk("R1 valid", 16'(v_a), 16'd0);
        chk("R1 product", p_a, 16'd0);
        chk("R1 product k255", p_f, 16'd0);
        @(negedge clk);
        rst = 1'b0;

        // R3/R6/R7: full back-to-back sweep on four coefficients
        for (int x = 0; x < 256; x++) begin
            cyc(1'b1, 8'(x));
            chk("R2 valid", 16'(v_a), 16'd1);
            chk("R3 sweep K=173", p_a, ref_mul(KA, x));
            chk("R6 K=0", p_0, 16'd0);
            chk("R6 K=1", p_1, ref_mul(1, x));
            chk("R7 K=255 back-to-back", p_f, ref_mul(255, x));
        end
        chk("R6 max product", p_f, 16'd65025);

        // R4: one nibble at a time
        cyc(1'b1, 8'h0F);
        chk("R4 low nibble", p_a, ref_mul(KA, 15));
        cyc(1'b1, 8'hF0);
        chk("R4 high nibble", p_a, ref_mul(KA, 240));
        cyc(1'b1, 8'h10);
        chk("R4 high weight", p_f, ref_mul(255, 16));

        // R5: idle cycles with changing data leave the product alone
        cyc(1'b1, 8'd77);
        ha = p_a;
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 8'($urandom));
            chk("R2 idle valid", 16'(v_a), 16'd0);
            chk("R5 hold", p_a, ha);
        end
        chk("R5 hold value", ha, ref_mul(KA, 77));

        // random mix of valid and idle cycles
        ha = p_a; h0 = p_0; h1 = p_1; hf = p_f;
        for (int i = 0; i < 400; i++) begin
            logic       v;
            logic [7:0] d;
            v = 1'($urandom);
            d = 8'($urandom);
            cyc(v, d);
            ev = v;
            if (v) begin
                ha = ref_mul(KA, d); h0 = 16'd0; h1 = ref_mul(1, d); hf = ref_mul(255, d);
            end
            chk("R2 random valid", 16'(v_a), 16'(ev));
            chk("R3 random", p_a, ha);
            chk("R5 random hold K=0", p_0, h0);
            chk("R5 random hold K=1", p_1, h1);
            chk("R5 random hold K=255", p_f, hf);
        end

        // R1: reset asserted while a valid sample arrives
        @(negedge clk);
        rst = 1'b1;
        cyc(1'b1, 8'd200);
        chk("R1 mid-stream valid", 16'(v_a), 16'd0);
        chk("R1 mid-stream product", p_a, 16'd0);
        @(negedge clk);
        rst = 1'b0;
        cyc(1'b1, 8'd3);
        chk("R3 after reset", p_a, ref_mul(KA, 3));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule